// File: doc/BRIEF.md
# Interruptible XOR Block Transform Engine

This engine runs memory to memory: it reads a block of data words from a source region, XORs each one with one of two key words, and writes the result to a destination region at the same offset. Software or a host sequencer gives it a source base, a destination base, a word count and two keys, then pulses `start_i`. The engine walks the block from the highest offset down to offset zero. The first word it handles uses key A, the second uses key B, and the two keys keep alternating in that way. It drives a single-port synchronous memory and has at most one request outstanding.

After each pair of words the engine samples an interrupt-pending input. It yields only when that input is high and the wakeup-disable count is zero. When it yields, `remain_o` holds the number of words still to do. Starting again with the same bases, keys and that remaining count finishes the block with the same result as a run that was never interrupted. The run time is fixed: 5 setup cycles plus 12 cycles per word. A cycle-accurate model can therefore follow the engine exactly.

Top module: `xbt_engine`

## Requirements
- R1: A start with a count of zero keeps `busy_o` high for exactly 5 cycles, writes nothing to memory, and ends with a `done_o` pulse.
- R2: Words are handled from offset count-1 down to offset 0. Each word is read from source base + offset and written to destination base + the same offset, in that order.
- R3: The first word handled is XORed with key A, the second with key B, and the keys alternate from there on.
- R4: `busy_o` is high for exactly 5 + 12·N cycles for N words handled. `done_o` (or `susp_o`) is a one-cycle pulse in the first cycle after `busy_o` falls.
- R5: Each word produces exactly one read request (`mem_we_o`=0) followed, two cycles later, by exactly one write request (`mem_we_o`=1). There are no requests while the engine is idle.
- R6: After the second word of a pair, if words remain, `irq_pend_i`=1 and `wake_dis_i`=0, the engine stops and pulses `susp_o`. `remain_o` then equals the number of words not yet handled.
- R7: The engine does not yield when `irq_pend_i` is low or `wake_dis_i` is non-zero, and it never yields after the first word of a pair.
- R8: Restarting with the same bases and keys and with count = `remain_o` finishes the block so that the memory matches an uninterrupted run.
- R9: `args_valid_o` is set by an accepted start, cleared on normal completion, and kept high on a yield.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The run in progress keeps its arguments and its timing.
- R11: Address sums wrap modulo 2^16.
- R12: `remain_o` is loaded with the count on start and drops by exactly one as each word begins.
- R13: Source and destination regions may overlap. The result follows the top-down order: each word is read before any lower-offset write can change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| src_base_i | input | 16 | Source region base word address |
| dst_base_i | input | 16 | Destination region base word address |
| count_i | input | 16 | Number of words to transform |
| key_a_i | input | 16 | Key for the first word and every second word after it |
| key_b_i | input | 16 | Key for the words in between |
| irq_pend_i | input | 1 | Interrupt pending, sampled after each word pair |
| wake_dis_i | input | 4 | Wakeup-disable count; yielding is allowed only when it is zero |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| susp_o | output | 1 | One-cycle pulse on a yield |
| remain_o | output | 16 | Count register (words still to do) |
| args_valid_o | output | 1 | Operand set loaded and not yet consumed |

## Verification
The bench builds the engine with its default parameters: 16-bit addresses, data and count, a 4-bit wakeup-disable count, 5 setup cycles and 12 cycles per word. With 16-bit addresses, a block that starts at 0xFFFE reaches the address wrap. The bench memory decodes only the low ten address bits, so the wrapped addresses land on distinct cells. The fixed 12-cycle word lets the bench predict the exact busy length of every run. Short counts of zero to nine words cover odd and even lengths, the yield after the first pair, and a resume that finishes the block.

// File: rtl/xbt_pkg.sv
// Package: shared types for the XOR block transform engine.
// Assumes: nothing beyond IEEE 1800-2017.
package xbt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WORD  = 2'd2
    } xbt_state_e;
endpackage

// File: rtl/xbt_yield.sv
// Module: yield decision. It permits a yield when an interrupt is
// pending and the wakeup-disable count is zero.
// Assumes: the sequencer samples yield_o only at a word-pair boundary.
module xbt_yield #(
    parameter int WDC_W = 4
) (
    input  logic             irq_pend_i,
    input  logic [WDC_W-1:0] wake_dis_i,
    output logic             yield_o
);
    // Combine the interrupt request with the disable count.
    always_comb begin
        yield_o = irq_pend_i && (wake_dis_i == '0);
    end
endmodule

// File: rtl/xbt_seq.sv
// Module: sequencer. It holds the state, the phase counter, the count
// register, the pair parity and the status pulses. Each word takes
// WORD_CYC cycles: a read in phase 0, read-data capture in phase 1 and a
// write in phase 2; the remaining phases pad the word to its fixed cost.
// Assumes: SETUP_CYC >= 1, WORD_CYC >= 3, memory read latency of one cycle.
module xbt_seq
    import xbt_pkg::*;
#(
    parameter int CW        = 16,
    parameter int SETUP_CYC = 5,
    parameter int WORD_CYC  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    input  logic          yield_i,
    output logic          load_o,
    output logic          rd_o,
    output logic          cap_o,
    output logic          wr_o,
    output logic          key_b_o,
    output logic [CW-1:0] cnt_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          susp_o,
    output logic          valid_o
);
    localparam int PH_MAX = (SETUP_CYC > WORD_CYC) ? SETUP_CYC : WORD_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] SETUP_LAST = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0] WORD_LAST  = PH_W'(WORD_CYC - 1);
    localparam logic [PH_W-1:0] PH_RD      = PH_W'(0);
    localparam logic [PH_W-1:0] PH_CAP     = PH_W'(1);
    localparam logic [PH_W-1:0] PH_WR      = PH_W'(2);

    xbt_state_e      state_q;
    logic [PH_W-1:0] ph_q;
    logic [CW-1:0]   cnt_q;
    logic            pair_q;
    logic            done_q;
    logic            susp_q;
    logic            valid_q;

    // Decode the per-phase strobes for the datapath.
    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i;
        rd_o    = (state_q == ST_WORD) && (ph_q == PH_RD);
        cap_o   = (state_q == ST_WORD) && (ph_q == PH_CAP);
        wr_o    = (state_q == ST_WORD) && (ph_q == PH_WR);
        key_b_o = pair_q;
        cnt_o   = cnt_q;
        busy_o  = (state_q != ST_IDLE);
        done_o  = done_q;
        susp_o  = susp_q;
        valid_o = valid_q;
    end

    // Advance the state, phase, count and pair parity; raise the status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            cnt_q   <= '0;
            pair_q  <= 1'b0;
            done_q  <= 1'b0;
            susp_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            susp_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SETUP;
                        ph_q    <= '0;
                        cnt_q   <= count_i;
                        pair_q  <= 1'b0;
                        valid_q <= 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (ph_q == SETUP_LAST) begin
                        ph_q <= '0;
                        if (cnt_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            valid_q <= 1'b0;
                        end else begin
                            state_q <= ST_WORD;
                            cnt_q   <= cnt_q - CW'(1);
                        end
                    end else begin
                        ph_q <= ph_q + PH_W'(1);
                    end
                end
                ST_WORD: begin
                    if (ph_q == WORD_LAST) begin
                        ph_q   <= '0;
                        pair_q <= ~pair_q;
                        if (cnt_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            valid_q <= 1'b0;
                        end else if (pair_q && yield_i) begin
                            state_q <= ST_IDLE;
                            susp_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - CW'(1);
                        end
                    end else begin
                        ph_q <= ph_q + PH_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xbt_dpath.sv
// Module: datapath. It latches the bases and keys on start, forms the read
// and write addresses from the current offset, captures the read data and
// XORs it with the selected key.
// Assumes: the strobes come from xbt_seq; read and write never coincide.
module xbt_dpath #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          rd_i,
    input  logic          cap_i,
    input  logic          wr_i,
    input  logic          key_b_i,
    input  logic [CW-1:0] off_i,
    input  logic [AW-1:0] src_base_i,
    input  logic [AW-1:0] dst_base_i,
    input  logic [DW-1:0] key_a_i,
    input  logic [DW-1:0] key_b_val_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o
);
    logic [AW-1:0] src_q, dst_q;
    logic [DW-1:0] ka_q, kb_q, rd_q;
    logic [AW-1:0] off_a;

    // Latch the operands at start and capture the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            ka_q  <= '0;
            kb_q  <= '0;
            rd_q  <= '0;
        end else begin
            if (load_i) begin
                src_q <= src_base_i;
                dst_q <= dst_base_i;
                ka_q  <= key_a_i;
                kb_q  <= key_b_val_i;
            end
            if (cap_i) begin
                rd_q <= mem_rdata_i;
            end
        end
    end

    // Form the memory request from the offset and the selected key.
    always_comb begin
        off_a       = AW'(off_i);
        mem_req_o   = rd_i || wr_i;
        mem_we_o    = wr_i;
        mem_addr_o  = wr_i ? (dst_q + off_a) : (src_q + off_a);
        mem_wdata_o = rd_q ^ (key_b_i ? kb_q : ka_q);
    end
endmodule

// File: rtl/xbt_engine.sv
// Module: top of the interruptible XOR block transform engine. It connects
// the sequencer, the datapath and the yield decision.
// Assumes: single-port synchronous memory with a one-cycle read latency.
module xbt_engine #(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int CW        = 16,
    parameter int WDC_W     = 4,
    parameter int SETUP_CYC = 5,
    parameter int WORD_CYC  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    src_base_i,
    input  logic [AW-1:0]    dst_base_i,
    input  logic [CW-1:0]    count_i,
    input  logic [DW-1:0]    key_a_i,
    input  logic [DW-1:0]    key_b_i,
    input  logic             irq_pend_i,
    input  logic [WDC_W-1:0] wake_dis_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             susp_o,
    output logic [CW-1:0]    remain_o,
    output logic             args_valid_o
);
    logic load_s, rd_s, cap_s, wr_s, keyb_s, yield_s;
    logic [CW-1:0] cnt_s;

    xbt_yield #(.WDC_W(WDC_W)) u_yield (
        .irq_pend_i (irq_pend_i),
        .wake_dis_i (wake_dis_i),
        .yield_o    (yield_s)
    );

    xbt_seq #(.CW(CW), .SETUP_CYC(SETUP_CYC), .WORD_CYC(WORD_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .count_i (count_i),
        .yield_i (yield_s),
        .load_o  (load_s),
        .rd_o    (rd_s),
        .cap_o   (cap_s),
        .wr_o    (wr_s),
        .key_b_o (keyb_s),
        .cnt_o   (cnt_s),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .susp_o  (susp_o),
        .valid_o (args_valid_o)
    );

    xbt_dpath #(.AW(AW), .DW(DW), .CW(CW)) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_s),
        .rd_i        (rd_s),
        .cap_i       (cap_s),
        .wr_i        (wr_s),
        .key_b_i     (keyb_s),
        .off_i       (cnt_s),
        .src_base_i  (src_base_i),
        .dst_base_i  (dst_base_i),
        .key_a_i     (key_a_i),
        .key_b_val_i (key_b_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

    assign remain_o = cnt_s;
endmodule

// File: rtl/xbt_engine_chk.sv
// Module: assertion checker for xbt_engine, attached with bind.
// Assumes: it observes only the ports of the top module.
module xbt_engine_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          susp_o,
    input logic [CW-1:0] remain_o,
    input logic          args_valid_o
);
    // R4: the done pulse lasts one cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4: the done pulse comes after busy has fallen
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R5: no memory request while idle
    p_no_req_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);
    // R5: each write follows a read two cycles earlier
    p_write_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o, 2));
    // R6: a yield and a completion never coincide
    p_end_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && susp_o));
    // R9: completion clears the operand-valid flag
    p_valid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !args_valid_o);
    // R9: a yield keeps the operand-valid flag
    p_valid_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        susp_o |-> args_valid_o);
    // R12: within a run the count only steps down by one
    p_count_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (remain_o != $past(remain_o)))
            |-> (remain_o == $past(remain_o) - CW'(1)));
endmodule

bind xbt_engine xbt_engine_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .susp_o       (susp_o),
    .remain_o     (remain_o),
    .args_valid_o (args_valid_o)
);

// File: tb/tb_xbt_engine.sv
// Directed bench for xbt_engine. The memory decodes the low 10 address bits.
module tb_xbt_engine;
    localparam int CLK_PERIOD = 10;
    localparam int MEMW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] src_base_i = '0, dst_base_i = '0, count_i = '0;
    logic [15:0] key_a_i = '0, key_b_i = '0;
    logic        irq_pend_i = 1'b0;
    logic [3:0]  wake_dis_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o, mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        busy_o, done_o, susp_o, args_valid_o;
    logic [15:0] remain_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [MEMW];
    logic [15:0] exp_mem [MEMW];
    logic [15:0] wr_log [64];
    int wr_n = 0;
    int rd_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbt_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_base_i(src_base_i), .dst_base_i(dst_base_i), .count_i(count_i),
        .key_a_i(key_a_i), .key_b_i(key_b_i),
        .irq_pend_i(irq_pend_i), .wake_dis_i(wake_dis_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .susp_o(susp_o),
        .remain_o(remain_o), .args_valid_o(args_valid_o)
    );

    // Synchronous single-port memory model with a write log.
    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) begin
                mem[mem_addr_o[9:0]] <= mem_wdata_o;
                if (wr_n < 64) wr_log[wr_n] <= mem_addr_o;
                wr_n <= wr_n + 1;
            end else begin
                mem_rdata_i <= mem[mem_addr_o[9:0]];
                rd_n <= rd_n + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MEMW; i++) begin
            mem[i]     = 16'(i * 16'h9E37) ^ 16'h5A5A;
            exp_mem[i] = mem[i];
        end
        wr_n = 0;
        rd_n = 0;
    endtask

    // Requirement model: top-down, alternating keys, sequential effects.
    task automatic model(input logic [15:0] s, d, c, ka, kb);
        int k = 0;
        for (int off = int'(c) - 1; off >= 0; off--) begin
            logic [15:0] sa, da;
            sa = s + 16'(off);
            da = d + 16'(off);
            exp_mem[da[9:0]] = exp_mem[sa[9:0]] ^ (((k % 2) == 0) ? ka : kb);
            k++;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < MEMW; i++) begin
            if (mem[i] !== exp_mem[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        check(bad == 0, req, "memory image mismatching words", bad, 0);
    endtask

    // Launch a run and wait for its end; returns busy length and end kind.
    task automatic run(input logic [15:0] s, d, c, ka, kb, input bit irq,
                       input logic [3:0] wdc, input bit inject,
                       output int bc, output bit got_done, output bit got_susp,
                       output logic [15:0] first_rem, output bit first_valid);
        int guard = 0;
        @(negedge clk);
        src_base_i = s; dst_base_i = d; count_i = c;
        key_a_i = ka; key_b_i = kb;
        irq_pend_i = irq; wake_dis_i = wdc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        first_rem = remain_o;
        first_valid = args_valid_o;
        bc = 0; got_done = 0; got_susp = 0;
        while (guard < 4000) begin
            if (busy_o) bc++;
            if (done_o || susp_o) begin
                got_done = done_o;
                got_susp = susp_o;
                break;
            end
            if (inject && bc == 20) begin
                src_base_i = 16'h0300; dst_base_i = 16'h0300;
                count_i = 16'd1; key_a_i = 16'hFFFF; key_b_i = 16'hFFFF;
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        check(guard < 4000, "R4", "run ended", guard, 0);
    endtask

    task automatic t_reset();
        check(busy_o == 0 && done_o == 0 && susp_o == 0, "R4", "idle after reset",
              {busy_o, done_o, susp_o}, 0);
        check(mem_req_o == 0, "R5", "no request after reset", mem_req_o, 0);
        check(args_valid_o == 0, "R9", "valid low after reset", args_valid_o, 0);
    endtask

    task automatic t_zero();
        int bc; bit dn, sp, fv; logic [15:0] fr;
        fill_mem();
        run(16'h0010, 16'h0080, 16'd0, 16'h1234, 16'h4321, 0, 0, 0, bc, dn, sp, fr, fv);
        check(bc == 5, "R1", "busy cycles for zero count", bc, 5);
        check(dn && !sp, "R1", "done pulse for zero count", {dn, sp}, 2);
        check(wr_n == 0, "R1", "writes for zero count", wr_n, 0);
        @(negedge clk);
        check(done_o == 0, "R4", "done is one cycle", done_o, 0);
    endtask

    task automatic t_basic(input logic [15:0] c, input logic [15:0] ka, kb);
        int bc; bit dn, sp, fv; logic [15:0] fr;
        logic [15:0] s = 16'h0020, d = 16'h0120;
        fill_mem();
        model(s, d, c, ka, kb);
        run(s, d, c, ka, kb, 0, 0, 0, bc, dn, sp, fr, fv);
        check(bc == 5 + 12 * int'(c), "R4", "busy cycles", bc, 5 + 12 * int'(c));
        check(dn && !sp, "R4", "done pulse at end", {dn, sp}, 2);
        check(fr == c, "R12", "remain loaded at start", fr, c);
        check(fv == 1'b1, "R9", "valid set on start", fv, 1);
        check(args_valid_o == 0, "R9", "valid cleared on completion", args_valid_o, 1'b0);
        check(wr_n == int'(c) && rd_n == int'(c), "R5", "one read and one write per word",
              wr_n * 1000 + rd_n, int'(c) * 1001);
        check(wr_log[0] == d + c - 16'd1, "R2", "first write at top offset", wr_log[0], d + c - 16'd1);
        check(wr_log[int'(c) - 1] == d, "R2", "last write at offset zero", wr_log[int'(c) - 1], d);
        cmp_mem("R3");
    endtask

    task automatic t_yield_resume();
        int bc; bit dn, sp, fv; logic [15:0] fr;
        logic [15:0] s = 16'h0040, d = 16'h0200;
        fill_mem();
        model(s, d, 16'd5, 16'hA5A5, 16'h0F0F);
        run(s, d, 16'd5, 16'hA5A5, 16'h0F0F, 1, 0, 0, bc, dn, sp, fr, fv);
        check(sp && !dn, "R6", "yield after first pair", {dn, sp}, 1);
        check(bc == 5 + 24, "R6", "busy cycles up to yield", bc, 29);
        check(remain_o == 16'd3, "R6", "remaining count at yield", remain_o, 3);
        check(wr_n == 2, "R7", "no yield after first word", wr_n, 2);
        check(args_valid_o == 1, "R9", "valid kept on yield", args_valid_o, 1);
        run(s, d, remain_o, 16'hA5A5, 16'h0F0F, 0, 0, 0, bc, dn, sp, fr, fv);
        check(dn && bc == 5 + 36, "R8", "resume completes", bc, 41);
        cmp_mem("R8");
    endtask

    task automatic t_wdc_block();
        int bc; bit dn, sp, fv; logic [15:0] fr;
        fill_mem();
        model(16'h0050, 16'h0250, 16'd4, 16'h1111, 16'h2222);
        run(16'h0050, 16'h0250, 16'd4, 16'h1111, 16'h2222, 1, 4'd3, 0, bc, dn, sp, fr, fv);
        check(dn && !sp, "R7", "no yield with disable count", {dn, sp}, 2);
        check(bc == 53, "R7", "full run length", bc, 53);
        cmp_mem("R7");
    endtask

    task automatic t_inject();
        int bc; bit dn, sp, fv; logic [15:0] fr;
        fill_mem();
        model(16'h0060, 16'h0160, 16'd3, 16'h7777, 16'h8888);
        run(16'h0060, 16'h0160, 16'd3, 16'h7777, 16'h8888, 0, 0, 1, bc, dn, sp, fr, fv);
        check(bc == 41, "R10", "busy length with start while busy", bc, 41);
        cmp_mem("R10");
    endtask

    task automatic t_wrap();
        int bc; bit dn, sp, fv; logic [15:0] fr;
        fill_mem();
        model(16'hFFFE, 16'hFFFD, 16'd4, 16'hC3C3, 16'h3C3C);
        run(16'hFFFE, 16'hFFFD, 16'd4, 16'hC3C3, 16'h3C3C, 0, 0, 0, bc, dn, sp, fr, fv);
        check(wr_log[0] == 16'h0000, "R11", "wrapped top write address", wr_log[0], 0);
        check(wr_log[3] == 16'hFFFD, "R11", "lowest write address", wr_log[3], 16'hFFFD);
        cmp_mem("R11");
    endtask

    task automatic t_overlap();
        int bc; bit dn, sp, fv; logic [15:0] fr;
        fill_mem();
        model(16'h0100, 16'h0101, 16'd4, 16'h0F0F, 16'hF0F0);
        run(16'h0100, 16'h0101, 16'd4, 16'h0F0F, 16'hF0F0, 0, 0, 0, bc, dn, sp, fr, fv);
        cmp_mem("R13");
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_basic(16'd1, 16'hAAAA, 16'h5555);
        t_basic(16'd6, 16'h1357, 16'h2468);
        t_basic(16'd9, 16'hFFFF, 16'h0001);
        t_yield_resume();
        t_wdc_block();
        t_inject();
        t_wrap();
        t_overlap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule